// File: doc/BRIEF.md
# PHY Loopback Control Sequencer

This block sits above an MDIO master and switches an external PHY's loopback on or off. A single command carries the requested direction (enable or disable). The sequencer first takes the shared PHY access lock. It then reads the PHY identifier and picks one of two register paths based on that value. Every change it makes is a read-modify-write of one bit, so all other bits keep their values.

The sequencer issues one MDIO request at a time and waits for the master's completion pulse before it issues the next. It holds the lock request for the whole sequence and drops it in the cycle it reports completion. A lock refusal ends the command early with an error flag, and no MDIO traffic is issued. While a command is in flight, further commands are dropped.

Top module: `phy_lpbk_seq`

## Requirements
- R1: During and just after reset, `busy_o`, `done_o`, `lock_req_o` and `mdio_req_o` are all 0.
- R2: A `cmd_valid_i` sampled while idle makes `busy_o` and `lock_req_o` go high in the next cycle, and `cmd_enable_i` (1 = loopback on, 0 = off) is captured at that edge.
- R3: A `lock_fail_i` pulse while waiting for the lock ends the command with `done_o`=1 and `err_o`=1 in the next cycle, and no MDIO request is issued.
- R4: After the lock is granted, the first MDIO access is a read (`mdio_we_o`=0) of register 2 in device 1, which returns the identifier.
- R5: If the identifier is 0x0043 or 0x0240, the sequencer reads register 0 of device 1 and writes it back with bit 0 set (enable) or cleared (disable). That is the only change.
- R6: For any other identifier, enable sets bit 2 of register 0xC017 in device 1 first, and then sets bit 15 of register 0xC000 in device 4.
- R7: For any other identifier, disable clears bit 15 of register 0xC000 in device 4 first, and then clears bit 2 of register 0xC017 in device 1.
- R8: Each change is a read of the register followed by a write (`mdio_we_o`=1) to the same device and register. The write data equals the read data with only the one target bit forced.
- R9: `mdio_req_o` is a one-cycle pulse, and no new request is issued until `mdio_done_i` has answered the previous one.
- R10: A command ends with a one-cycle `done_o` pulse. On success `err_o` is 0 in that cycle, `lock_req_o` is already low, and `busy_o` falls in the following cycle.
- R11: A `cmd_valid_i` sampled while busy is ignored. The sequence in flight, its direction and its ordering are unaffected, and no extra access follows.
- R12: `lock_req_o` stays high from command acceptance until the done cycle, and every MDIO request is issued only after `lock_gnt_i` has been seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_enable_i | input | 1 | 1 = turn loopback on, 0 = turn it off |
| busy_o | output | 1 | Command in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Valid with done_o; 1 = lock refused |
| lock_req_o | output | 1 | Requests and holds the PHY access lock |
| lock_gnt_i | input | 1 | Lock granted pulse |
| lock_fail_i | input | 1 | Lock refused pulse |
| mdio_req_o | output | 1 | One-cycle MDIO access request |
| mdio_we_o | output | 1 | Access type: 1 = write, 0 = read |
| mdio_dev_o | output | DEV_W | Target device address |
| mdio_reg_o | output | REG_W | Target register address |
| mdio_wdata_o | output | DATA_W | Write data |
| mdio_rdata_i | input | DATA_W | Read data, valid with mdio_done_i |
| mdio_done_i | input | 1 | One-cycle completion of the outstanding access |

## Verification
The assertions assume a well-behaved lock arbiter and MDIO master. The arbiter answers a lock request with exactly one grant or refusal pulse and only while the request is held. The master returns exactly one `mdio_done_i` pulse per request, at least one cycle later, with read data valid in that cycle. The bench's lock and MDIO responders follow these rules, with an adjustable response latency. Stray commands are injected only while a sequence is clearly mid-flight, never on the idle or done cycles.

// File: rtl/phy_lpbk_pkg.sv
package phy_lpbk_pkg;

  typedef enum logic [2:0] {
    T_IDLE,
    T_LOCK,
    T_ID,
    T_STEP,
    T_FIN
  } seq_st_e;

  typedef enum logic [2:0] {
    E_IDLE,
    E_RD_REQ,
    E_RD_WAIT,
    E_WR_REQ,
    E_WR_WAIT
  } rmw_st_e;

endpackage

// File: rtl/phy_lpbk_steps.sv
module phy_lpbk_steps #(
  parameter int unsigned DEV_W   = 5,
  parameter int unsigned REG_W   = 16,
  parameter int unsigned BIT_W   = 4,
  parameter int unsigned CTL_DEV = 1,
  parameter int unsigned CTL_REG = 0,
  parameter int unsigned CTL_BIT = 0,
  parameter int unsigned VND_DEV = 1,
  parameter int unsigned VND_REG = 'hC017,
  parameter int unsigned VND_BIT = 2,
  parameter int unsigned XS_DEV  = 4,
  parameter int unsigned XS_REG  = 'hC000,
  parameter int unsigned XS_BIT  = 15
) (
  input  logic             known_i,
  input  logic             enable_i,
  input  logic             idx_i,
  output logic [DEV_W-1:0] dev_o,
  output logic [REG_W-1:0] reg_o,
  output logic [BIT_W-1:0] bit_o,
  output logic             last_o
);

  logic use_xs;

  // disable walks the two-register path backwards
  assign use_xs = enable_i ? idx_i : ~idx_i;

  always_comb begin
    if (known_i) begin
      dev_o  = DEV_W'(CTL_DEV);
      reg_o  = REG_W'(CTL_REG);
      bit_o  = BIT_W'(CTL_BIT);
      last_o = 1'b1;
    end else if (use_xs) begin
      dev_o  = DEV_W'(XS_DEV);
      reg_o  = REG_W'(XS_REG);
      bit_o  = BIT_W'(XS_BIT);
      last_o = idx_i;
    end else begin
      dev_o  = DEV_W'(VND_DEV);
      reg_o  = REG_W'(VND_REG);
      bit_o  = BIT_W'(VND_BIT);
      last_o = idx_i;
    end
  end

endmodule

// File: rtl/phy_lpbk_rmw.sv
module phy_lpbk_rmw
  import phy_lpbk_pkg::*;
#(
  parameter int unsigned DEV_W  = 5,
  parameter int unsigned REG_W  = 16,
  parameter int unsigned DATA_W = 16,
  localparam int unsigned BIT_W = $clog2(DATA_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              rd_only_i,
  input  logic              set_i,
  input  logic [DEV_W-1:0]  dev_i,
  input  logic [REG_W-1:0]  reg_i,
  input  logic [BIT_W-1:0]  bit_i,
  output logic              done_o,
  output logic              mdio_req_o,
  output logic              mdio_we_o,
  output logic [DEV_W-1:0]  mdio_dev_o,
  output logic [REG_W-1:0]  mdio_reg_o,
  output logic [DATA_W-1:0] mdio_wdata_o,
  input  logic [DATA_W-1:0] mdio_rdata_i,
  input  logic              mdio_done_i
);

  rmw_st_e           st_q;
  logic              ronly_q, set_q;
  logic [DEV_W-1:0]  dev_q;
  logic [REG_W-1:0]  reg_q;
  logic [BIT_W-1:0]  bit_q;
  logic [DATA_W-1:0] rd_q, mask;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= E_IDLE;
      ronly_q <= 1'b0;
      set_q   <= 1'b0;
      dev_q   <= '0;
      reg_q   <= '0;
      bit_q   <= '0;
      rd_q    <= '0;
    end else begin
      unique case (st_q)
        E_IDLE: if (start_i) begin
          ronly_q <= rd_only_i;
          set_q   <= set_i;
          dev_q   <= dev_i;
          reg_q   <= reg_i;
          bit_q   <= bit_i;
          st_q    <= E_RD_REQ;
        end
        E_RD_REQ: st_q <= E_RD_WAIT;
        E_RD_WAIT: if (mdio_done_i) begin
          rd_q <= mdio_rdata_i;
          st_q <= ronly_q ? E_IDLE : E_WR_REQ;
        end
        E_WR_REQ: st_q <= E_WR_WAIT;
        E_WR_WAIT: if (mdio_done_i) st_q <= E_IDLE;
        default: st_q <= E_IDLE;
      endcase
    end
  end

  assign mask         = DATA_W'(1) << bit_q;
  assign mdio_wdata_o = set_q ? (rd_q | mask) : (rd_q & ~mask);
  assign mdio_req_o   = (st_q == E_RD_REQ) || (st_q == E_WR_REQ);
  assign mdio_we_o    = (st_q == E_WR_REQ) || (st_q == E_WR_WAIT);
  assign mdio_dev_o   = dev_q;
  assign mdio_reg_o   = reg_q;
  assign done_o       = mdio_done_i &&
                        ((st_q == E_WR_WAIT) || (st_q == E_RD_WAIT && ronly_q));

  p_one_req_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mdio_req_o |=> !mdio_req_o);

  p_keep_bits_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mdio_req_o && mdio_we_o) |-> ($countones(mdio_wdata_o ^ rd_q) <= 1));

  p_start_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> (st_q == E_IDLE));

endmodule

// File: rtl/phy_lpbk_seq.sv
module phy_lpbk_seq
  import phy_lpbk_pkg::*;
#(
  parameter int unsigned DEV_W    = 5,
  parameter int unsigned REG_W    = 16,
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned ID_DEV   = 1,
  parameter int unsigned ID_REG   = 2,
  parameter int unsigned ID_A     = 'h0043,
  parameter int unsigned ID_B     = 'h0240,
  parameter int unsigned CTL_DEV  = 1,
  parameter int unsigned CTL_REG  = 0,
  parameter int unsigned CTL_BIT  = 0,
  parameter int unsigned VND_DEV  = 1,
  parameter int unsigned VND_REG  = 'hC017,
  parameter int unsigned VND_BIT  = 2,
  parameter int unsigned XS_DEV   = 4,
  parameter int unsigned XS_REG   = 'hC000,
  parameter int unsigned XS_BIT   = 15
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic              cmd_enable_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic              lock_req_o,
  input  logic              lock_gnt_i,
  input  logic              lock_fail_i,
  output logic              mdio_req_o,
  output logic              mdio_we_o,
  output logic [DEV_W-1:0]  mdio_dev_o,
  output logic [REG_W-1:0]  mdio_reg_o,
  output logic [DATA_W-1:0] mdio_wdata_o,
  input  logic [DATA_W-1:0] mdio_rdata_i,
  input  logic              mdio_done_i
);

  localparam int unsigned BIT_W = $clog2(DATA_W);

  seq_st_e          st_q;
  logic             en_q, known_q, idx_q, go_q, err_q;
  logic [DEV_W-1:0] t_dev, e_dev;
  logic [REG_W-1:0] t_reg, e_reg;
  logic [BIT_W-1:0] t_bit, e_bit;
  logic             t_last, e_ronly, e_done, id_hit;

  phy_lpbk_steps #(
    .DEV_W(DEV_W), .REG_W(REG_W), .BIT_W(BIT_W),
    .CTL_DEV(CTL_DEV), .CTL_REG(CTL_REG), .CTL_BIT(CTL_BIT),
    .VND_DEV(VND_DEV), .VND_REG(VND_REG), .VND_BIT(VND_BIT),
    .XS_DEV(XS_DEV), .XS_REG(XS_REG), .XS_BIT(XS_BIT)
  ) u_steps (
    .known_i (known_q),
    .enable_i(en_q),
    .idx_i   (idx_q),
    .dev_o   (t_dev),
    .reg_o   (t_reg),
    .bit_o   (t_bit),
    .last_o  (t_last)
  );

  always_comb begin
    if (st_q == T_ID) begin
      e_dev   = DEV_W'(ID_DEV);
      e_reg   = REG_W'(ID_REG);
      e_bit   = '0;
      e_ronly = 1'b1;
    end else begin
      e_dev   = t_dev;
      e_reg   = t_reg;
      e_bit   = t_bit;
      e_ronly = 1'b0;
    end
  end

  phy_lpbk_rmw #(
    .DEV_W(DEV_W), .REG_W(REG_W), .DATA_W(DATA_W)
  ) u_rmw (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (go_q),
    .rd_only_i   (e_ronly),
    .set_i       (en_q),
    .dev_i       (e_dev),
    .reg_i       (e_reg),
    .bit_i       (e_bit),
    .done_o      (e_done),
    .mdio_req_o  (mdio_req_o),
    .mdio_we_o   (mdio_we_o),
    .mdio_dev_o  (mdio_dev_o),
    .mdio_reg_o  (mdio_reg_o),
    .mdio_wdata_o(mdio_wdata_o),
    .mdio_rdata_i(mdio_rdata_i),
    .mdio_done_i (mdio_done_i)
  );

  assign id_hit = (mdio_rdata_i == DATA_W'(ID_A)) || (mdio_rdata_i == DATA_W'(ID_B));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= T_IDLE;
      en_q    <= 1'b0;
      known_q <= 1'b0;
      idx_q   <= 1'b0;
      go_q    <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      go_q <= 1'b0;
      unique case (st_q)
        T_IDLE: if (cmd_valid_i) begin
          en_q  <= cmd_enable_i;
          err_q <= 1'b0;
          st_q  <= T_LOCK;
        end
        T_LOCK: begin
          if (lock_fail_i) begin
            err_q <= 1'b1;
            st_q  <= T_FIN;
          end else if (lock_gnt_i) begin
            go_q <= 1'b1;
            st_q <= T_ID;
          end
        end
        T_ID: if (e_done) begin
          known_q <= id_hit;
          idx_q   <= 1'b0;
          go_q    <= 1'b1;
          st_q    <= T_STEP;
        end
        T_STEP: if (e_done) begin
          if (t_last) begin
            st_q <= T_FIN;
          end else begin
            idx_q <= 1'b1;
            go_q  <= 1'b1;
          end
        end
        T_FIN: st_q <= T_IDLE;
        default: st_q <= T_IDLE;
      endcase
    end
  end

  assign busy_o     = (st_q != T_IDLE);
  assign done_o     = (st_q == T_FIN);
  assign err_o      = (st_q == T_FIN) && err_q;
  assign lock_req_o = (st_q == T_LOCK) || (st_q == T_ID) || (st_q == T_STEP);

  p_req_locked_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mdio_req_o |-> (lock_req_o && st_q != T_LOCK));

  p_done_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_done_unlock_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !lock_req_o);

  p_hold_dir_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o) |=> $stable(en_q));

  p_fail_ends_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == T_LOCK && lock_fail_i) |=> (done_o && err_o));

  p_accept_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && cmd_valid_i) |=> (busy_o && lock_req_o));

endmodule

// File: tb/phy_lpbk_seq_bench.sv
module phy_lpbk_seq_bench;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cmd_valid_i = 1'b0, cmd_enable_i = 1'b0;
  logic        lock_gnt_i = 1'b0, lock_fail_i = 1'b0;
  logic        mdio_done_i = 1'b0;
  logic [15:0] mdio_rdata_i = '0;
  logic        busy_o, done_o, err_o, lock_req_o;
  logic        mdio_req_o, mdio_we_o;
  logic [4:0]  mdio_dev_o;
  logic [15:0] mdio_reg_o, mdio_wdata_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  phy_lpbk_seq u_phy_lpbk_seq (
    .clk_i(clk), .rst_ni(rst_ni),
    .cmd_valid_i(cmd_valid_i), .cmd_enable_i(cmd_enable_i),
    .busy_o(busy_o), .done_o(done_o), .err_o(err_o),
    .lock_req_o(lock_req_o), .lock_gnt_i(lock_gnt_i), .lock_fail_i(lock_fail_i),
    .mdio_req_o(mdio_req_o), .mdio_we_o(mdio_we_o),
    .mdio_dev_o(mdio_dev_o), .mdio_reg_o(mdio_reg_o),
    .mdio_wdata_o(mdio_wdata_o), .mdio_rdata_i(mdio_rdata_i),
    .mdio_done_i(mdio_done_i)
  );

  typedef struct {
    bit    we;
    int    dev;
    int    rg;
    int    data;
    string tag;
  } xact_t;

  xact_t q[$];
  int    mem[int];
  int    n_chk = 0, n_bad = 0;
  int    lat = 1;
  bit    run = 0, exp_busy = 0, fin_pending = 0, drop_next = 0, exp_err = 0;
  bit    lock_deny = 0, lock_answered = 0, lock_granted = 0;

  task automatic chk(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int key(int dev, int rg);
    return dev * 65536 + rg;
  endfunction

  function automatic int rd(int dev, int rg);
    return mem.exists(key(dev, rg)) ? mem[key(dev, rg)] : 0;
  endfunction

  function automatic void push(bit we, int dev, int rg, int d, string tag);
    xact_t x;
    x.we = we; x.dev = dev; x.rg = rg; x.data = d; x.tag = tag;
    q.push_back(x);
  endfunction

  function automatic void push_rmw(int dev, int rg, int b, bit en, string tag);
    int v;
    v = rd(dev, rg);
    push(0, dev, rg, 0, tag);
    push(1, dev, rg, en ? (v | (1 << b)) : (v & ~(1 << b)) & 'hFFFF, tag);
  endfunction

  // per-clock reference comparison of the handshake outputs
  always @(negedge clk) begin
    if (run) begin
      if (drop_next) begin
        exp_busy  = 0;
        drop_next = 0;
      end
      chk(busy_o == exp_busy, "R2 R10 busy", busy_o, exp_busy);
      chk(lock_req_o == (exp_busy && !fin_pending), "R12 lock_req", lock_req_o,
          exp_busy && !fin_pending);
      chk(done_o == fin_pending, "R10 done", done_o, fin_pending);
      if (fin_pending) begin
        chk(err_o == exp_err, "R3 R10 err", err_o, exp_err);
        fin_pending = 0;
        drop_next   = 1;
      end
    end
  end

  // lock arbiter
  initial forever begin
    @(negedge clk);
    if (!lock_req_o) begin
      lock_answered = 0;
      lock_granted  = 0;
    end else if (!lock_answered) begin
      lock_answered = 1;
      @(posedge clk); #1;
      if (lock_deny) lock_fail_i = 1'b1; else lock_gnt_i = 1'b1;
      @(posedge clk); #1;
      if (lock_fail_i) fin_pending = 1; else lock_granted = 1;
      lock_fail_i = 1'b0;
      lock_gnt_i  = 1'b0;
    end
  end

  // MDIO master and PHY register model
  initial forever begin
    @(negedge clk);
    if (mdio_req_o) begin
      bit          we;
      int          dev, rg;
      logic [15:0] wd;
      xact_t       e;
      we = mdio_we_o; dev = int'(mdio_dev_o); rg = int'(mdio_reg_o); wd = mdio_wdata_o;
      chk(lock_granted, "R12 request before grant", 0, 1);
      if (q.size() == 0) begin
        chk(0, "R11 R9 unexpected request", key(dev, rg), 0);
      end else begin
        e = q.pop_front();
        chk(we == e.we, {e.tag, " R8 access type"}, we, e.we);
        chk(dev == e.dev && rg == e.rg, {e.tag, " target"}, key(dev, rg), key(e.dev, e.rg));
        if (we) chk(int'(wd) == e.data, {e.tag, " R8 write data"}, wd, e.data);
      end
      for (int i = 0; i < lat; i++) begin
        @(negedge clk);
        chk(!mdio_req_o, "R9 request while outstanding", 1, 0);
      end
      @(posedge clk); #1;
      if (we) mem[key(dev, rg)] = int'(wd);
      else mdio_rdata_i = 16'(rd(dev, rg));
      mdio_done_i = 1'b1;
      @(posedge clk); #1;
      mdio_done_i = 1'b0;
      if (q.size() == 0) fin_pending = 1;
    end
  end

  task automatic run_cmd(bit en, bit deny, int l, bit stray);
    int id;
    q.delete();
    if (!deny) begin
      push(0, 1, 2, 0, "R4 id read");
      id = rd(1, 2);
      if (id == 'h43 || id == 'h240) begin
        push_rmw(1, 0, 0, en, "R5");
      end else if (en) begin
        push_rmw(1, 'hC017, 2, 1, "R6 first");
        push_rmw(4, 'hC000, 15, 1, "R6 second");
      end else begin
        push_rmw(4, 'hC000, 15, 0, "R7 first");
        push_rmw(1, 'hC017, 2, 0, "R7 second");
      end
    end
    exp_err = deny; lock_deny = deny; lat = l;
    @(posedge clk); #1;
    cmd_valid_i = 1'b1; cmd_enable_i = en;
    @(posedge clk); #1;
    cmd_valid_i = 1'b0;
    exp_busy = 1;
    if (stray) begin
      repeat (4) @(posedge clk);
      #1; cmd_valid_i = 1'b1; cmd_enable_i = ~en;
      @(posedge clk); #1;
      cmd_valid_i = 1'b0;
    end
    while (exp_busy) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(q.size() == 0, "R9 R11 missing accesses", q.size(), 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog R10 actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy_o && !done_o && !lock_req_o && !mdio_req_o, "R1 reset outputs",
        {busy_o, done_o, lock_req_o, mdio_req_o}, 0);
    @(posedge clk); #1;
    rst_ni = 1'b1;
    @(negedge clk);
    chk(!busy_o && !lock_req_o, "R1 after reset", {busy_o, lock_req_o}, 0);
    run = 1;

    // known id, enable: R5
    mem[key(1, 2)] = 'h0043; mem[key(1, 0)] = 'h1230;
    run_cmd(1, 0, 1, 0);
    chk(rd(1, 0) == 'h1231, "R5 enable result", rd(1, 0), 'h1231);

    // second known id, disable, all bits set: R5 R8
    mem[key(1, 2)] = 'h0240; mem[key(1, 0)] = 'hFFFF;
    run_cmd(0, 0, 3, 0);
    chk(rd(1, 0) == 'hFFFE, "R5 disable result", rd(1, 0), 'hFFFE);

    // other id, enable, with a stray command mid-flight: R6 R11
    mem[key(1, 2)] = 'h1234; mem[key(1, 'hC017)] = 'h00A0; mem[key(4, 'hC000)] = 'h0001;
    run_cmd(1, 0, 2, 1);
    chk(rd(1, 'hC017) == 'h00A4, "R6 vendor reg", rd(1, 'hC017), 'h00A4);
    chk(rd(4, 'hC000) == 'h8001, "R6 xs reg", rd(4, 'hC000), 'h8001);

    // other id, disable: R7
    mem[key(1, 'hC017)] = 'hFFFF; mem[key(4, 'hC000)] = 'hFFFF;
    run_cmd(0, 0, 1, 1);
    chk(rd(4, 'hC000) == 'h7FFF, "R7 xs reg", rd(4, 'hC000), 'h7FFF);
    chk(rd(1, 'hC017) == 'hFFFB, "R7 vendor reg", rd(1, 'hC017), 'hFFFB);

    // lock refused: R3
    run_cmd(1, 1, 1, 0);

    // near-miss id, bits already set: R6 R8
    mem[key(1, 2)] = 'h0042; mem[key(1, 0)] = 'h0000;
    mem[key(1, 'hC017)] = 'h0004; mem[key(4, 'hC000)] = 'h8000;
    run_cmd(1, 0, 4, 0);
    chk(rd(1, 0) == 0, "R6 ctl untouched", rd(1, 0), 0);
    chk(rd(1, 'hC017) == 'h0004, "R8 vendor kept", rd(1, 'hC017), 'h0004);

    // command straight after a failure still works: R2 R5
    mem[key(1, 2)] = 'h0043; mem[key(1, 0)] = 'h0001;
    run_cmd(0, 0, 1, 0);
    chk(rd(1, 0) == 0, "R5 clear bit", rd(1, 0), 0);

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule